// File: doc/BRIEF.md
# Configurable Timer Channel Counter

This block is one 16-bit counting channel of a multi-channel timer. A 7-bit control register selects where count events come from: one of five taps of a free-running prescaler on the system clock, one of two asynchronous external clock pins, or the overflow pulse of a neighbouring channel. The same register selects which edges of an external pin count. It also selects the condition that returns the counter to zero.

Four 16-bit general registers hold compare values. Whenever the counter advances, the block compares the value it held with each general register and reports each equality as a one-cycle match pulse. One of the clear settings makes the counter return to zero on the count event after it has reached general register A or B. Another clear setting lets a neighbouring channel's synchronous clear request reset this counter.

A one-cycle overflow pulse marks a natural wrap from all ones to zero, so channels can be chained. A simple synchronous write bus and a combinational read port give access to every register.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, all four general registers read 0xFFFF, and ovf_pulse and match are low.
- R2: Bus map: address 0 is the control register, with bits 6:0 stored and bit 7 always reading 0. Address 1 is the counter. Addresses 2, 3, 4 and 5 are general registers A, B, C and D.
- R3: Control bits 2:0 set to 000, 001, 010, 011 or 110 make the counter advance exactly once every 1, 4, 16, 64 or 1024 system clock cycles.
- R4: Control bits 2:0 set to 100 count edges of ext_a, and 101 count edges of ext_c. Both pins pass through a two-flop synchronizer. Control bits 4:3 select the edges that count: 00 counts rising edges, 01 counts falling edges, and 10 or 11 count both. The pin that is not selected has no effect.
- R5: Control bits 2:0 set to 111 advance the counter once for each clock cycle in which casc_in is high. The edge setting has no effect on this source or on the prescaler taps.
- R6: A count event at 0xFFFF that is not turned into a clear makes the counter 0. In the same cycle ovf_pulse goes high for exactly one cycle.
- R7: With control bits 6:5 = 01, a count event while the counter equals general register A loads 0 instead of incrementing. With 10, the same applies using general register B.
- R8: With control bits 6:5 = 11, sync_clr_in high while sync_en is high clears the counter at the next clock edge. With sync_en low, sync_clr_in has no effect.
- R9: match[i] pulses high for one cycle after a count event during which the counter equalled general register i (A=bit 0 through D=bit 3).
- R10: A bus write to the counter takes priority over a count event or a clear in the same cycle.
- R11: With control bits 6:5 = 00 the counter is never cleared by a match and counts past the general register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ext_a | input | 1 | External clock pin A (asynchronous) |
| ext_c | input | 1 | External clock pin C (asynchronous) |
| casc_in | input | 1 | Overflow pulse from the cascaded channel |
| sync_en | input | 1 | Synchronous operation enable |
| sync_clr_in | input | 1 | Synchronous clear request from another channel |
| ovf_pulse | output | 1 | One-cycle wrap pulse |
| match | output | 4 | One-cycle compare match pulses, A..D |

## Verification
A corrupted prescaler divider or a wrong tap decode changes the count delta over a window of whole periods. The counter read port shows this within one prescaler period. A broken synchronizer or edge decoder shows up as a wrong pin-edge count about three cycles after the pin toggles. A wrong compare or clear path appears on the very next count event, either as a counter that fails to return to zero or as a missing or extra match or overflow pulse.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W    = 16,
  parameter int DIVW = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         ext_a,
  input  logic         ext_c,
  input  logic         casc_in,
  input  logic         sync_en,
  input  logic         sync_clr_in,
  output logic         ovf_pulse,
  output logic [3:0]   match
);

  localparam int NGR = 4;

  logic [6:0]      ctrl;
  logic [W-1:0]    gr [NGR];
  logic [W-1:0]    cnt;
  logic [DIVW-1:0] div;
  logic [1:0]      sa, sc;
  logic            pa, pc;

  wire [2:0] src = ctrl[2:0];
  wire [1:0] edg = ctrl[4:3];
  wire [1:0] clr = ctrl[6:5];

  wire t4  = &div[1:0];
  wire t16 = &div[3:0];
  wire t64 = &div[5:0];
  wire t1k = &div[9:0];

  wire xs     = src[0] ? sc[1] : sa[1];
  wire xp     = src[0] ? pc : pa;
  wire rise   = xs & ~xp;
  wire fall   = ~xs & xp;
  wire ext_ev = edg[1] ? (rise | fall) : (edg[0] ? fall : rise);

  logic cnt_ev;
  always_comb begin
    case (src)
      3'b000:  cnt_ev = 1'b1;
      3'b001:  cnt_ev = t4;
      3'b010:  cnt_ev = t16;
      3'b011:  cnt_ev = t64;
      3'b110:  cnt_ev = t1k;
      3'b111:  cnt_ev = casc_in;
      default: cnt_ev = ext_ev;
    endcase
  end

  wire hit    = (clr == 2'b01 && cnt == gr[0]) || (clr == 2'b10 && cnt == gr[1]);
  wire sclr   = (clr == 2'b11) && sync_en && sync_clr_in;
  wire cnt_wr = bus_wr && bus_addr == 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      sa  <= '0;
      sc  <= '0;
      pa  <= 1'b0;
      pc  <= 1'b0;
    end else begin
      div <= div + 1'b1;
      sa  <= {sa[0], ext_a};
      sc  <= {sc[0], ext_c};
      pa  <= sa[1];
      pc  <= sc[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      for (int i = 0; i < NGR; i++) gr[i] <= '1;
    end else if (bus_wr) begin
      if (bus_addr == 3'd0) ctrl <= bus_wdata[6:0];
      for (int i = 0; i < NGR; i++)
        if (bus_addr == 3'(i + 2)) gr[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ovf_pulse <= 1'b0;
      match     <= '0;
    end else begin
      if (cnt_wr)      cnt <= bus_wdata;
      else if (sclr)   cnt <= '0;
      else if (cnt_ev) cnt <= hit ? '0 : cnt + 1'b1;
      ovf_pulse <= !cnt_wr && !sclr && cnt_ev && !hit && (&cnt);
      for (int i = 0; i < NGR; i++) match[i] <= cnt_ev && (cnt == gr[i]);
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {{(W-7){1'b0}}, ctrl};
      3'd1:    bus_rdata = cnt;
      3'd2:    bus_rdata = gr[0];
      3'd3:    bus_rdata = gr[1];
      3'd4:    bus_rdata = gr[2];
      3'd5:    bus_rdata = gr[3];
      default: bus_rdata = '0;
    endcase
  end

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(bus_wdata));

  p_sync_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclr && !cnt_wr) |=> cnt == '0);

  p_match_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ev && hit && !cnt_wr && !sclr) |=> cnt == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ev && !hit && !cnt_wr && !sclr) |=> cnt == W'($past(cnt) + 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ev && !cnt_wr && !sclr) |=> $stable(cnt));

  p_ovf_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> cnt == '0);

endmodule

// File: tb/tmr_chan_tb.sv
`timescale 1ns/1ps
module tmr_chan_tb;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic ext_a = 0, ext_c = 0, casc_in = 0, sync_en = 0, sync_clr_in = 0;
  logic ovf_pulse;
  logic [3:0] match;
  int errors = 0, checks = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  tmr_chan u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_a(ext_a), .ext_c(ext_c),
    .casc_in(casc_in), .sync_en(sync_en), .sync_clr_in(sync_clr_in),
    .ovf_pulse(ovf_pulse), .match(match));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic casc_pulse();
    @(negedge clk); casc_in = 1;
    @(negedge clk); casc_in = 0;
  endtask

  task automatic pin(input bit sel_c, input logic v);
    @(negedge clk);
    if (sel_c) ext_c = v; else ext_a = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v, c0, c1;
    int per [5];
    logic [2:0] code [5];
    per = '{1, 4, 16, 64, 1024};
    code = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b110};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2, v); chk("R1 grA", v, 16'hFFFF);
    rd(3, v); chk("R1 grB", v, 16'hFFFF);
    rd(4, v); chk("R1 grC", v, 16'hFFFF);
    rd(5, v); chk("R1 grD", v, 16'hFFFF);
    chk("R1 ovf", {15'd0, ovf_pulse}, 16'h0);
    chk("R1 match", {12'd0, match}, 16'h0);
    // R2 map, bit 7 reads 0
    wr(0, 16'h00FF); rd(0, v); chk("R2 ctrl bit7", v, 16'h007F);
    wr(0, 16'h0007);
    for (int i = 0; i < 4; i++) begin
      wr(3'(i + 2), 16'h1100 + 16'(i));
      rd(3'(i + 2), v); chk("R2 gr readback", v, 16'h1100 + 16'(i));
    end
    wr(1, 16'h0042); rd(1, v); chk("R2 cnt readback", v, 16'h0042);
    // R3 prescaler sweep
    for (int k = 0; k < 5; k++) begin
      wr(0, {13'd0, code[k]});
      rd(1, c0);
      repeat (per[k] * 5) @(negedge clk);
      rd(1, c1);
      chk("R3 prescaler delta", c1 - c0, 16'd5);
    end
    // R4 external pins, edge sweep
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 4; e++) begin
        wr(0, {9'd0, 2'b00, 2'(e), (s == 1) ? 3'b101 : 3'b100});
        repeat (4) @(negedge clk);
        rd(1, c0);
        pin(s == 1, 1); pin(s == 1, 0); pin(s == 1, 1); pin(s == 1, 0);
        rd(1, c1);
        chk("R4 edge count", c1 - c0, (e >= 2) ? 16'd4 : 16'd2);
        pin(s != 1, 1); pin(s != 1, 0);
        rd(1, c0);
        chk("R4 other pin ignored", c0 - c1, 16'd0);
      end
    end
    // R5 cascade, edge setting ignored
    wr(0, 16'h001F); wr(1, 16'h0000);
    repeat (3) casc_pulse();
    rd(1, v); chk("R5 cascade count", v, 16'd3);
    repeat (5) @(negedge clk);
    rd(1, v); chk("R5 hold without pulse", v, 16'd3);
    // R6 wrap
    wr(0, 16'h0007); wr(1, 16'hFFFF);
    casc_pulse();
    rd(1, v); chk("R6 wrap value", v, 16'h0000);
    chk("R6 ovf high", {15'd0, ovf_pulse}, 16'h1);
    @(negedge clk);
    chk("R6 ovf one cycle", {15'd0, ovf_pulse}, 16'h0);
    // R7 / R9 clear on A
    wr(2, 16'd3); wr(0, 16'h0027); wr(1, 16'd0);
    repeat (3) casc_pulse();
    rd(1, v); chk("R7 reach A", v, 16'd3);
    chk("R9 no match yet", {12'd0, match}, 16'h0);
    casc_pulse();
    rd(1, v); chk("R7 clear on A", v, 16'd0);
    chk("R9 match A", {12'd0, match}, 16'h1);
    @(negedge clk);
    chk("R9 match one cycle", {12'd0, match}, 16'h0);
    // R7 clear on B
    wr(3, 16'd2); wr(0, 16'h0047); wr(1, 16'd0);
    repeat (3) casc_pulse();
    rd(1, v); chk("R7 clear on B", v, 16'd0);
    // R9 match D without clear, R11 no clear
    wr(5, 16'd4); wr(0, 16'h0007); wr(1, 16'd0);
    repeat (5) casc_pulse();
    rd(1, v); chk("R11 passes A", v, 16'd5);
    wr(1, 16'd4); casc_pulse();
    chk("R9 match D", {12'd0, match}, 16'h8);
    // R8 sync clear
    wr(0, 16'h0067); wr(1, 16'd100);
    sync_en = 0;
    @(negedge clk); sync_clr_in = 1; @(negedge clk); sync_clr_in = 0;
    rd(1, v); chk("R8 ignored without enable", v, 16'd100);
    sync_en = 1;
    @(negedge clk); sync_clr_in = 1; @(negedge clk); sync_clr_in = 0;
    rd(1, v); chk("R8 sync clear", v, 16'd0);
    sync_en = 0;
    // R10 write priority
    wr(0, 16'h0000);
    @(negedge clk); bus_wr = 1; bus_addr = 1; bus_wdata = 16'h1234;
    @(negedge clk); bus_wr = 0;
    rd(1, v); chk("R10 write wins", v, 16'h1234);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule